// File: doc/BRIEF.md
# Dot-Product Element Controller

This block is one processing element of a matrix engine. It forms the signed integer dot product of one row vector and one column vector of fixed length, then offers the sum to a result collector and waits until the collector takes it. After each hand-off it clears its accumulator and is ready for the next row/column pair. It keeps doing this without a new start; only a reset returns it to its idle state.

A single start pulse wakes the element from idle. It then spends a fixed warm-up period flushing its multiply-accumulate pipeline before it asks for operands. Operand pairs arrive with a valid strobe. The request flag drops one pair early, so a source that reacts one cycle late never sends a surplus pair. After the last pair, the element waits out the pipeline latency and then presents the sum. The multiply-accumulate unit is a behavioural four-stage pipeline with a synchronous clear. Its accumulator is wide enough that no vector of the configured length can overflow it. The vector length must be at least 2.

Top module: `dpe_unit`

## Requirements
- R1: A synchronous reset puts the element in idle with `take_o`, `sum_vld_o` low and `sum_o` zero. In idle, operand strobes and acknowledges have no effect. A `start_i` sampled in any state other than idle is ignored.
- R2: When `start_i` is sampled high in idle, the element warms up for exactly four cycles with `take_o` low. `take_o` first goes high after the fourth clock edge following the start edge.
- R3: While the element is collecting operands, every clock edge that samples `pair_vld_i` high accepts the pair (`a_i`, `b_i`), whether or not `take_o` is high. `take_o` stays high while fewer than VEC_LEN-1 pairs have been accepted.
- R4: `take_o` goes low once VEC_LEN-1 pairs have been accepted, and the last pair is still accepted. Pairs strobed after the VEC_LEN-th, or while no collection is running, do not change any sum.
- R5: The edge that accepts the last pair is followed by four drain edges. `sum_vld_o` rises after the fourth of them.
- R6: While `sum_vld_o` is high, `sum_o` equals the signed sum of a_i*b_i over the VEC_LEN accepted pairs. Both `sum_o` and `sum_vld_o` hold until `sum_ack_i` is sampled high. `sum_o` is zero whenever `sum_vld_o` is low.
- R7: The edge that samples `sum_ack_i` high with `sum_vld_o` high starts one clear cycle in which `take_o` and `sum_vld_o` are low. Collection then resumes with a zeroed accumulator and a zero pair count.
- R8: `sum_o` is 2*OP_W + clog2(VEC_LEN+1) bits wide, two's complement, and never wraps. With OP_W=8 and VEC_LEN=5: all pairs (-128,-128) give 81920, and all pairs (-128,127) give -81280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, honoured only in idle |
| take_o | output | 1 | Request for further operand pairs |
| pair_vld_i | input | 1 | Operand pair valid strobe |
| a_i | input | OP_W | Row element, signed |
| b_i | input | OP_W | Column element, signed |
| sum_o | output | 2*OP_W+clog2(VEC_LEN+1) | Dot product, signed |
| sum_vld_o | output | 1 | Result valid, held until acknowledged |
| sum_ack_i | input | 1 | Result taken by the collector |

## Verification
Result hand-off and operand acceptance can fall in the same cycle. A source that keeps `pair_vld_i` high through the writeback, the acknowledge edge and the clear cycle drives them together. The reference must show the result unchanged by those strobes. The next sum must then contain only the pairs accepted after collection resumes, counted from the first edge of the new collection. A start pulse held high during busy states checks that a redundant start collides harmlessly with every phase.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WARM,
        ST_RUN,
        ST_DRAIN,
        ST_PRESENT,
        ST_FLUSH
    } dpe_state_e;

    // cycles spent flushing the pipeline before operands are requested
    localparam int unsigned WARM_CYC = 4;
    // pair-in to accumulator-out latency of the multiply-accumulate pipe
    localparam int unsigned MAC_LAT  = 4;

endpackage

// File: rtl/dpe_mac.sv
module dpe_mac #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 36
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    clr,
    input  logic                    in_vld,
    input  logic signed [OP_W-1:0]  a,
    input  logic signed [OP_W-1:0]  b,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam int PROD_W = 2 * OP_W;

    typedef struct packed {
        logic                     v1;
        logic signed [OP_W-1:0]   a1;
        logic signed [OP_W-1:0]   b1;
        logic                     v2;
        logic signed [PROD_W-1:0] p2;
        logic                     v3;
        logic signed [PROD_W-1:0] p3;
        logic signed [ACC_W-1:0]  acc;
    } mac_regs_t;

    mac_regs_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (en) begin
            d.v1 = in_vld;
            d.a1 = a;
            d.b1 = b;
            d.v2 = q.v1;
            d.p2 = q.a1 * q.b1;
            d.v3 = q.v2;
            d.p3 = q.p2;
            if (q.v3) begin
                d.acc = q.acc + ACC_W'(q.p3);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc;

    // R7: a clear leaves an empty accumulator on the next cycle
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_o == '0));

    // R8: adding a term of the same sign never flips the accumulator sign
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (q.v3 && en && !clr && (q.acc[ACC_W-1] == q.p3[PROD_W-1]))
        |=> (acc_o[ACC_W-1] == $past(q.acc[ACC_W-1])));

endmodule

// File: rtl/dpe_seq.sv
module dpe_seq
    import dpe_pkg::*;
#(
    parameter int VEC_LEN = 16,
    parameter int ACC_W   = 36
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    pair_vld,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic                    sum_ack,
    output logic                    take_o,
    output logic                    mac_en,
    output logic                    mac_clr,
    output logic                    mac_in_vld,
    output logic signed [ACC_W-1:0] sum_o,
    output logic                    sum_vld_o
);
    localparam int WAIT_MAX = (WARM_CYC > MAC_LAT) ? WARM_CYC : MAC_LAT;
    localparam int TICK_W   = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
    localparam int CNT_W    = (VEC_LEN > 2) ? $clog2(VEC_LEN) : 1;
    localparam logic [TICK_W-1:0] WARM_LAST  = TICK_W'(WARM_CYC - 1);
    localparam logic [TICK_W-1:0] DRAIN_LAST = TICK_W'(MAC_LAT - 1);
    localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(VEC_LEN - 1);

    typedef struct packed {
        dpe_state_e        state;
        logic [TICK_W-1:0] tick;
        logic [CNT_W-1:0]  cnt;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_WARM;
                    d.tick  = '0;
                end
            end
            ST_WARM: begin
                if (q.tick == WARM_LAST) begin
                    d.state = ST_RUN;
                    d.cnt   = '0;
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
            ST_RUN: begin
                if (pair_vld) begin
                    if (q.cnt == CNT_LAST) begin
                        d.state = ST_DRAIN;
                        d.tick  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (q.tick == DRAIN_LAST) begin
                    d.state = ST_PRESENT;
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
            ST_PRESENT: begin
                if (sum_ack) begin
                    d.state = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                d.state = ST_RUN;
                d.cnt   = '0;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{state: ST_IDLE, tick: '0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        take_o     = (q.state == ST_RUN) && (q.cnt < CNT_LAST);
        mac_en     = (q.state == ST_WARM) || (q.state == ST_RUN) || (q.state == ST_DRAIN);
        mac_clr    = (q.state == ST_IDLE) || (q.state == ST_FLUSH);
        mac_in_vld = (q.state == ST_RUN) && pair_vld;
        sum_vld_o  = (q.state == ST_PRESENT);
        sum_o      = (q.state == ST_PRESENT) ? acc_i : '0;
    end

    // R1: idle drives no handshake
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_IDLE) |-> (!take_o && !sum_vld_o));

    // R2: the cycle after a start is a warm-up cycle with no request
    a_r2_warm_no_take: assert property (@(posedge clk) disable iff (rst)
        ((q.state == ST_IDLE) && start) |=> !take_o);

    // R5: a result only appears straight out of the drain period
    a_r5_after_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(sum_vld_o) |-> ($past(q.state) == ST_DRAIN));

    // R6: unacknowledged result is held steady
    a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
        (sum_vld_o && !sum_ack) |=> (sum_vld_o && $stable(sum_o)));

    // R7: an acknowledge leads into a quiet clear cycle
    a_r7_clear_cycle: assert property (@(posedge clk) disable iff (rst)
        (sum_vld_o && sum_ack) |=> (!sum_vld_o && !take_o && mac_clr));

endmodule

// File: rtl/dpe_unit.sv
module dpe_unit #(
    parameter  int OP_W    = 16,
    parameter  int VEC_LEN = 16,
    localparam int ACC_W   = 2 * OP_W + $clog2(VEC_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    output logic                    take_o,
    input  logic                    pair_vld_i,
    input  logic signed [OP_W-1:0]  a_i,
    input  logic signed [OP_W-1:0]  b_i,
    output logic signed [ACC_W-1:0] sum_o,
    output logic                    sum_vld_o,
    input  logic                    sum_ack_i
);
    logic                    mac_en;
    logic                    mac_clr;
    logic                    mac_in_vld;
    logic signed [ACC_W-1:0] acc;

    dpe_seq #(
        .VEC_LEN (VEC_LEN),
        .ACC_W   (ACC_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .pair_vld   (pair_vld_i),
        .acc_i      (acc),
        .sum_ack    (sum_ack_i),
        .take_o     (take_o),
        .mac_en     (mac_en),
        .mac_clr    (mac_clr),
        .mac_in_vld (mac_in_vld),
        .sum_o      (sum_o),
        .sum_vld_o  (sum_vld_o)
    );

    dpe_mac #(
        .OP_W  (OP_W),
        .ACC_W (ACC_W)
    ) u_mac (
        .clk    (clk),
        .rst    (rst),
        .en     (mac_en),
        .clr    (mac_clr),
        .in_vld (mac_in_vld),
        .a      (a_i),
        .b      (b_i),
        .acc_o  (acc)
    );

    // R4: the request is never up while a result is being presented
    a_r4_no_take_in_writeback: assert property (@(posedge clk) disable iff (rst)
        sum_vld_o |-> !take_o);

endmodule

// File: tb/sim_dpe_unit.sv
module sim_dpe_unit;
    localparam int W   = 8;
    localparam int L   = 5;
    localparam int AW  = 2 * W + $clog2(L + 1);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic                 pair_vld_i = 1'b0;
    logic signed [W-1:0]  a_i = '0;
    logic signed [W-1:0]  b_i = '0;
    logic                 sum_ack_i = 1'b0;
    logic                 take_o;
    logic signed [AW-1:0] sum_o;
    logic                 sum_vld_o;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #4 clk = ~clk;

    dpe_unit #(.OP_W(W), .VEC_LEN(L)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .take_o     (take_o),
        .pair_vld_i (pair_vld_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .sum_o      (sum_o),
        .sum_vld_o  (sum_vld_o),
        .sum_ack_i  (sum_ack_i)
    );

    // behavioural reference: phase number, counters and a queue of products
    int     m_phase = 0;
    int     m_tick  = 0;
    int     m_got   = 0;
    longint m_sum   = 0;
    longint m_prods[$];

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0;
            m_prods.delete();
        end else begin
            case (m_phase)
                0: if (start_i) begin m_phase = 1; m_tick = 0; end
                1: if (m_tick == 3) begin m_phase = 2; m_got = 0; m_prods.delete(); end
                   else m_tick++;
                2: if (pair_vld_i) begin
                       m_prods.push_back(longint'(a_i) * longint'(b_i));
                       m_got++;
                       if (m_got == L) begin m_phase = 3; m_tick = 0; end
                   end
                3: if (m_tick == 3) begin
                       m_phase = 4;
                       m_sum = 0;
                       foreach (m_prods[i]) m_sum += m_prods[i];
                   end else m_tick++;
                4: if (sum_ack_i) m_phase = 5;
                default: begin m_phase = 2; m_got = 0; m_prods.delete(); end
            endcase
        end
    end

    function automatic string tag_of(int ph);
        case (ph)
            0: return "R1";
            1: return "R2";
            2: return "R3 R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    bit     cmp_on = 0;
    bit     exp_take, exp_vld;
    longint exp_sum;

    always @(negedge clk) begin
        if (!rst && cmp_on && !finished) begin
            exp_take = (m_phase == 2) && (m_got < L - 1);
            exp_vld  = (m_phase == 4);
            exp_sum  = (m_phase == 4) ? m_sum : 0;
            compared++;
            if (take_o !== exp_take || sum_vld_o !== exp_vld ||
                longint'(sum_o) !== exp_sum) begin
                mismatched++;
                $display("FAIL %s: take=%0b/%0b vld=%0b/%0b sum=%0d/%0d (actual/expected)",
                         tag_of(m_phase), take_o, exp_take, sum_vld_o, exp_vld,
                         longint'(sum_o), exp_sum);
            end
        end
    end

    task automatic drive(input bit s, input bit v, input int a, input int b, input bit ack);
        @(negedge clk);
        start_i    = s;
        pair_vld_i = v;
        a_i        = W'(a);
        b_i        = W'(b);
        sum_ack_i  = ack;
    endtask

    task automatic check_value(input string tag, input longint act, input longint exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // run a constant pair until a result shows, then check it and acknowledge
    task automatic const_run(input int a, input int b, input longint exp);
        int n = 0;
        drive(1'b0, 1'b1, a, b, 1'b0);
        while (!sum_vld_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        check_value("R8 extreme sum", longint'(sum_o), exp);
        drive(1'b0, 1'b1, a, b, 1'b1);
        drive(1'b0, 1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_value("R1 take after reset", longint'(take_o), 0);
        check_value("R1 valid after reset", longint'(sum_vld_o), 0);
        check_value("R1 sum after reset", longint'(sum_o), 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: strobes and acks in idle do nothing
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, i, -i, 1'b1);

        // R2..R7: start, always-valid source, immediate ack (ack collides with strobes)
        drive(1'b1, 1'b1, 3, 4, 1'b0);
        for (int i = 0; i < 200; i++)
            drive(1'b0, 1'b1, int'($urandom_range(255)), int'($urandom_range(255)), 1'b1);

        // gapped source, late acknowledge, redundant start pulses
        for (int i = 0; i < 500; i++)
            drive((i % 13) == 0, (i % 3) != 1, int'($urandom_range(255)),
                  int'($urandom_range(255)), (i % 7) == 0);

        // quiet until any pending result is collected
        for (int i = 0; i < 40; i++) drive(1'b0, 1'b0, 0, 0, (i % 4) == 3);

        // R8: extreme operands
        const_run(-128, -128, 81920);
        const_run(-128, 127, -81280);
        const_run(127, 127, 80645);

        // reset in the middle of a run, then restart
        for (int i = 0; i < 7; i++) drive(1'b0, 1'b1, 5, 5, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 1'b1, 1, 1, 1'b1);
        drive(1'b0, 1'b1, 1, 1, 1'b1);
        rst = 1'b0;
        check_value("R1 take after mid-run reset", longint'(take_o), 0);
        drive(1'b0, 1'b1, 9, 9, 1'b0);
        drive(1'b1, 1'b0, 0, 0, 1'b0);
        for (int i = 0; i < 300; i++)
            drive(1'b1, (i % 5) != 2, int'($urandom_range(255)),
                  int'($urandom_range(255)), (i % 3) == 0);
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, 0, 0, 1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule